// File: doc/BRIEF.md
# IR Receiver Status and Interrupt Register Block

This block is the host-facing register set of a consumer infrared receiver and transmitter. Edge samples from the IR front end arrive on a valid/data input and are queued in a byte FIFO. The host drains that FIFO one byte per read of the receive data register. A status register reports four events: transmit finished, transmit underrun, receive timeout and receive data available. The same status byte holds an interrupt-enable bit. A level interrupt output is raised while the enable bit is set and any event is pending.

Software acknowledges the transmit events by writing ones to their bit positions. The two receive events clear themselves. They stay set until the host has read every queued byte, and a write of one to them is ignored while data remains. The receive timeout fires when the FIFO holds data and no new sample has arrived for a programmable number of sample periods, counted on a sample-period strobe. A control register holds that period count. A transmit control register and a transmit data register are held for the transmitter, and each write of transmit data is signalled to it by a one-cycle load strobe.

Top module: `ir_rx_regs`

## Requirements
- R1: After reset the status register reads 0x00, irq_o is low, and a read of the receive data register (address 2) returns 0x00.
- R2: Accepted samples are returned in arrival order, one byte per read of address 2, and each such read removes one byte.
- R3: Status bit 0 (data available) reads 1 while the FIFO holds data and 0 once the last byte has been read; writing 1 to bit 0 while data remains leaves it set.
- R4: Status bit 1 (receive timeout) becomes 1 once the FIFO is non-empty and LIMIT sample-period strobes have occurred since the last accepted sample, where LIMIT is the control register at address 1. Each new sample restarts the count, and a LIMIT of 0 disables the timeout.
- R5: Once set, the timeout flag stays set until the FIFO is empty, ignoring writes of 1 to bit 1, and reads 0 as soon as the last byte is read.
- R6: Status bit 3 (transmit finished) and bit 2 (transmit underrun) are set by pulses on tx_done_i and tx_underrun_i. Each is cleared only by writing 1 to its own bit of the status register at address 0; writing 0 to it leaves it unchanged.
- R7: Status bit 7 is a read/write interrupt enable, and irq_o is high exactly when bit 7 is set and any of status bits 3..0 is set.
- R8: A read of address 2 while the FIFO is empty returns 0x00 and leaves the FIFO intact. A later sample is then read back correctly and the FIFO is empty again afterwards.
- R9: Samples that arrive while the FIFO holds DEPTH bytes are discarded, and the first DEPTH samples are kept.
- R10: Address 3 (transmit control) and address 4 (transmit data) are read/write registers that drive tx_ctrl_o and tx_data_o. A write to address 4 raises tx_load_o for exactly one cycle, in the cycle the new value appears.
- R11: If a transmit event pulse and a write of 1 to the same status bit occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Host access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address: 0 status, 1 control, 2 rx data, 3 tx control, 4 tx data |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| sample_valid_i | input | 1 | Sample strobe from the front end |
| sample_i | input | 8 | Sample byte |
| tick_i | input | 1 | One strobe per sample period |
| tx_done_i | input | 1 | Transmit finished pulse |
| tx_underrun_i | input | 1 | Transmit underrun pulse |
| tx_ctrl_o | output | 8 | Transmit control register value |
| tx_data_o | output | 8 | Transmit data register value |
| tx_load_o | output | 1 | One-cycle strobe after a transmit data write |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that the FIFO count never exceeds its depth and that a read on an empty FIFO leaves the count at zero. They also check that the timeout flag is never held over an empty FIFO, that a transmit event always lands in its flag, that a one-write clears the flag when no event competes, and that a new enabled event raises the interrupt. The bench scenarios show what needs a sequence to observe. These are arrival-order readback, the exact strobe on which the timeout fires, the restart of the count by a new sample, and the discarding of samples beyond the depth. They also cover the ignored acknowledge writes on the receive flags and the one-cycle load strobe.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] A_STATUS  = 3'd0;
  localparam logic [REG_AW-1:0] A_CTRL    = 3'd1;
  localparam logic [REG_AW-1:0] A_RXDATA  = 3'd2;
  localparam logic [REG_AW-1:0] A_TXCTRL  = 3'd3;
  localparam logic [REG_AW-1:0] A_TXDATA  = 3'd4;

  // status bit positions (software decodes these)
  localparam int unsigned B_RXAV = 0;
  localparam int unsigned B_RXTO = 1;
  localparam int unsigned B_TXUR = 2;
  localparam int unsigned B_TXFN = 3;
  localparam int unsigned B_IEN  = 7;
  localparam int unsigned NFLAGS = 4;
endpackage

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = empty_o ? '0 : mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (do_push && wr_q == PW'(g))   mem_q[g] <= din_i;
    end
  end
endmodule

// File: rtl/ir_rx_idle.sv
module ir_rx_idle #(
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          active_i,
  input  logic [LW-1:0] limit_i,
  output logic          hit_o
);
  logic [LW-1:0] cnt_q;
  logic          armed;

  assign armed = active_i & ~restart_i & tick_i & (limit_i != '0) & (cnt_q != limit_i);
  assign hit_o = armed & ((cnt_q + LW'(1)) == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i || !active_i) cnt_q <= '0;
    else if (armed)                 cnt_q <= cnt_q + LW'(1);
  end
endmodule

// File: rtl/ir_rx_stat.sv
module ir_rx_stat
  import ir_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              tx_done_i,
  input  logic              tx_underrun_i,
  input  logic              to_hit_i,
  input  logic              fifo_empty_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_en_o,
  output logic              to_raw_o
);
  logic txfn_q, txur_q, to_q, ien_q;

  // set beats acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txfn_q <= 1'b0;
      txur_q <= 1'b0;
      to_q   <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (tx_done_i)                     txfn_q <= 1'b1;
      else if (wr_i && wdata_i[B_TXFN])  txfn_q <= 1'b0;
      if (tx_underrun_i)                 txur_q <= 1'b1;
      else if (wr_i && wdata_i[B_TXUR])  txur_q <= 1'b0;
      if (fifo_empty_i)                  to_q <= 1'b0;
      else if (to_hit_i)                 to_q <= 1'b1;
      if (wr_i)                          ien_q <= wdata_i[B_IEN];
    end
  end

  always_comb begin
    flags_o         = '0;
    flags_o[B_RXAV] = ~fifo_empty_i;
    flags_o[B_RXTO] = to_q & ~fifo_empty_i;
    flags_o[B_TXUR] = txur_q;
    flags_o[B_TXFN] = txfn_q;
  end

  assign irq_en_o = ien_q;
  assign to_raw_o = to_q;
endmodule

// File: rtl/ir_rx_regs.sv
module ir_rx_regs
  import ir_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [REG_DW-1:0] bus_wdata_i,
  output logic [REG_DW-1:0] bus_rdata_o,
  input  logic              sample_valid_i,
  input  logic [REG_DW-1:0] sample_i,
  input  logic              tick_i,
  input  logic              tx_done_i,
  input  logic              tx_underrun_i,
  output logic [REG_DW-1:0] tx_ctrl_o,
  output logic [REG_DW-1:0] tx_data_o,
  output logic              tx_load_o,
  output logic              irq_o
);
  logic              wr_en, rd_en, st_wr, rd_pop;
  logic [REG_DW-1:0] fifo_dout, limit_q, txc_q, txd_q;
  logic              fifo_empty, fifo_full, to_hit, to_raw, irq_en, load_q;
  logic [CW-1:0]     fifo_cnt;
  logic [NFLAGS-1:0] flags;

  assign wr_en  = bus_sel_i & bus_we_i;
  assign rd_en  = bus_sel_i & ~bus_we_i;
  assign st_wr  = wr_en & (bus_addr_i == A_STATUS);
  assign rd_pop = rd_en & (bus_addr_i == A_RXDATA);

  ir_rx_fifo #(.DW(REG_DW), .DEPTH(DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sample_valid_i),
    .din_i   (sample_i),
    .pop_i   (rd_pop),
    .dout_o  (fifo_dout),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );

  ir_rx_idle #(.LW(REG_DW)) idle_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (sample_valid_i),
    .active_i  (~fifo_empty),
    .limit_i   (limit_q),
    .hit_o     (to_hit)
  );

  ir_rx_stat stat_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (st_wr),
    .wdata_i       (bus_wdata_i),
    .tx_done_i     (tx_done_i),
    .tx_underrun_i (tx_underrun_i),
    .to_hit_i      (to_hit),
    .fifo_empty_i  (fifo_empty),
    .flags_o       (flags),
    .irq_en_o      (irq_en),
    .to_raw_o      (to_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
      txc_q   <= '0;
      txd_q   <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= wr_en & (bus_addr_i == A_TXDATA);
      if (wr_en && bus_addr_i == A_CTRL)   limit_q <= bus_wdata_i;
      if (wr_en && bus_addr_i == A_TXCTRL) txc_q   <= bus_wdata_i;
      if (wr_en && bus_addr_i == A_TXDATA) txd_q   <= bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_STATUS: begin
        bus_rdata_o[NFLAGS-1:0] = flags;
        bus_rdata_o[B_IEN]      = irq_en;
      end
      A_CTRL:   bus_rdata_o = limit_q;
      A_RXDATA: bus_rdata_o = fifo_dout;
      A_TXCTRL: bus_rdata_o = txc_q;
      A_TXDATA: bus_rdata_o = txd_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign tx_ctrl_o = txc_q;
  assign tx_data_o = txd_q;
  assign tx_load_o = load_q;
  assign irq_o     = irq_en & (|flags);
endmodule

// File: rtl/ir_rx_regs_chk.sv
module ir_rx_regs_chk
  import ir_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CW-1:0]     cnt,
  input logic              push,
  input logic              pop,
  input logic              full,
  input logic              to_raw,
  input logic              st_wr,
  input logic [REG_DW-1:0] wdata,
  input logic              tx_done,
  input logic [NFLAGS-1:0] flags,
  input logic              irq_en,
  input logic              irq
);
  // R9
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));

  // R8
  p_empty_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && cnt == '0 && !push) |=> cnt == '0);

  // R2
  p_push_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !full && !pop) |=> cnt == $past(cnt) + CW'(1));

  // R5
  p_to_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |=> !to_raw);

  // R6
  p_txfn_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done |=> flags[B_TXFN]);

  p_txfn_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wdata[B_TXFN] && !tx_done) |=> !flags[B_TXFN]);

  // R7
  p_irq_on_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flags[B_TXFN]) && irq_en) |-> irq);
endmodule

bind ir_rx_regs ir_rx_regs_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt     (fifo_cnt),
  .push    (sample_valid_i),
  .pop     (rd_pop),
  .full    (fifo_full),
  .to_raw  (to_raw),
  .st_wr   (st_wr),
  .wdata   (bus_wdata_i),
  .tx_done (tx_done_i),
  .flags   (flags),
  .irq_en  (irq_en),
  .irq     (irq_o)
);

// File: tb/ir_rx_regs_tb.sv
module ir_rx_regs_tb_top;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       svalid = 1'b0;
  logic [7:0] sdata = '0;
  logic       tick = 1'b0, txd = 1'b0, txu = 1'b0;
  logic [7:0] txc_o, txd_o;
  logic       load_o, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ir_rx_regs #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sample_valid_i(svalid), .sample_i(sdata), .tick_i(tick),
    .tx_done_i(txd), .tx_underrun_i(txu),
    .tx_ctrl_o(txc_o), .tx_data_o(txd_o), .tx_load_o(load_o),
    .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FIL%s %s: actual 0x%02h expected 0x%02h", "", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic push(logic [7:0] v);
    @(negedge clk); svalid = 1; sdata = v;
    @(negedge clk); svalid = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd0, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(3'd2, v); chk("R1 rxdata", v, 8'h00);
  endtask

  task automatic t_order;
    logic [7:0] v;
    push(8'hA1); push(8'hB2); push(8'hC3);
    rd(3'd0, v); chk("R3 avail", v, 8'h01);
    wr(3'd0, 8'h03);
    rd(3'd0, v); chk("R3 ack ignored", v, 8'h01);
    rd(3'd2, v); chk("R2 byte0", v, 8'hA1);
    rd(3'd2, v); chk("R2 byte1", v, 8'hB2);
    rd(3'd0, v); chk("R3 still avail", v, 8'h01);
    rd(3'd2, v); chk("R2 byte2", v, 8'hC3);
    rd(3'd0, v); chk("R3 cleared", v, 8'h00);
  endtask

  task automatic t_empty;
    logic [7:0] v;
    rd(3'd2, v); chk("R8 empty read", v, 8'h00);
    rd(3'd2, v); chk("R8 empty read 2", v, 8'h00);
    push(8'h5A);
    rd(3'd2, v); chk("R8 after empty", v, 8'h5A);
    rd(3'd0, v); chk("R8 empty again", v, 8'h00);
  endtask

  task automatic t_full;
    logic [7:0] v;
    for (int i = 0; i < DEPTH + 2; i++) push(8'(8'h10 + i));
    for (int i = 0; i < DEPTH; i++) begin
      rd(3'd2, v); chk("R9 kept", v, 8'(8'h10 + i));
    end
    rd(3'd2, v); chk("R9 dropped", v, 8'h00);
    rd(3'd0, v); chk("R9 empty", v, 8'h00);
  endtask

  task automatic t_timeout;
    logic [7:0] v;
    wr(3'd1, 8'd3);
    rd(3'd1, v); chk("R4 limit rb", v, 8'd3);
    push(8'h77);
    ticks(2);
    rd(3'd0, v); chk("R4 before limit", v, 8'h01);
    push(8'h78);
    ticks(2);
    rd(3'd0, v); chk("R4 restarted", v, 8'h01);
    ticks(1);
    rd(3'd0, v); chk("R4 fired", v, 8'h03);
    wr(3'd0, 8'h02);
    rd(3'd0, v); chk("R5 ack ignored", v, 8'h03);
    rd(3'd2, v); chk("R5 byte0", v, 8'h77);
    rd(3'd0, v); chk("R5 held", v, 8'h03);
    rd(3'd2, v); chk("R5 byte1", v, 8'h78);
    rd(3'd0, v); chk("R5 cleared", v, 8'h00);
    wr(3'd1, 8'd0);
    push(8'h11);
    ticks(6);
    rd(3'd0, v); chk("R4 disabled", v, 8'h01);
    rd(3'd2, v); chk("R4 drain", v, 8'h11);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    @(negedge clk); txd = 1; @(negedge clk); txd = 0;
    rd(3'd0, v); chk("R6 txfn set", v, 8'h08);
    chk("R7 irq off", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h80);
    rd(3'd0, v); chk("R6 zero write", v, 8'h88);
    chk("R7 irq on", {7'd0, irq}, 8'h01);
    @(negedge clk); txu = 1; @(negedge clk); txu = 0;
    rd(3'd0, v); chk("R6 txur set", v, 8'h8C);
    wr(3'd0, 8'h88);
    rd(3'd0, v); chk("R6 txfn ack", v, 8'h84);
    wr(3'd0, 8'h84);
    rd(3'd0, v); chk("R6 txur ack", v, 8'h80);
    chk("R7 irq idle", {7'd0, irq}, 8'h00);
    push(8'h42);
    chk("R7 irq rx", {7'd0, irq}, 8'h01);
    rd(3'd2, v);
    chk("R7 irq rx gone", {7'd0, irq}, 8'h00);
    // R11: event and acknowledge together
    @(negedge clk); txd = 1; sel = 1; we = 1; addr = 3'd0; wdata = 8'h88;
    @(negedge clk); txd = 0; sel = 0; we = 0;
    rd(3'd0, v); chk("R11 set wins", v, 8'h88);
    wr(3'd0, 8'h08);
    rd(3'd0, v); chk("R11 cleanup", v, 8'h00);
  endtask

  task automatic t_txregs;
    logic [7:0] v;
    wr(3'd3, 8'h5C);
    chk("R10 txctrl out", txc_o, 8'h5C);
    chk("R10 no load", {7'd0, load_o}, 8'h00);
    @(negedge clk); sel = 1; we = 1; addr = 3'd4; wdata = 8'hA7;
    @(negedge clk); sel = 0; we = 0;
    chk("R10 load high", {7'd0, load_o}, 8'h01);
    chk("R10 txdata out", txd_o, 8'hA7);
    @(negedge clk);
    chk("R10 load low", {7'd0, load_o}, 8'h00);
    rd(3'd3, v); chk("R10 txctrl rb", v, 8'h5C);
    rd(3'd4, v); chk("R10 txdata rb", v, 8'hA7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_order();
    t_empty();
    t_full();
    t_timeout();
    t_tx();
    t_txregs();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule